// File: doc/BRIEF.md
# Performance Event Counter Unit

This block counts processor activity for profiling software. It holds one free-running cycle counter and a parameterised number of event counters, four by default. Each event counter watches one line of a bundle of event inputs. Software picks that line per counter by writing an event number. Software controls everything through a small register-bus slave, which has an address, a write strobe, write data and combinational read data. A single interrupt line tells software that a counter it cares about has overflowed.

Software sets a counter up by loading it with the two's complement of the sampling period, enabling it and enabling its interrupt. When the counter passes from all-ones to zero, its overflow flag sets and the interrupt rises. The handler reads the flags, clears them by writing ones, and reloads the counters. The event counters are reached indirectly: a select register names one of them, and two windows give access to that counter's event number and count. The cycle counter can be slowed by a divide-by-64 prescaler, and it can be held while an external debug-state input is high. The counting pulses of the event counters can also be exported.

Top module: `perfmon_unit`

## Requirements
- R1: The control register at address 0 stores bit 0 (global run), bit 3 (divide cycle counter by 64), bit 4 (export) and bit 5 (hold cycle counter in debug state). Bits 1 and 2 always read as 0, and every other bit is ignored on write and reads as 0.
- R2: Writing 1 to control bit 1 clears all event counts. Writing 1 to control bit 2 clears the cycle count and the prescaler. Either clear is visible from the cycle after the write and takes priority over loading or counting.
- R3: Counter-mask layout: bit k (k < 4) is event counter k and bit 31 is the cycle counter. Writing ones to address 1 enables the matching counters, and writing ones to address 2 disables them. Zero bits change nothing, and both addresses read back the current enable mask.
- R4: The overflow flags at address 4 use the counter-mask layout. A counter's flag sets on the cycle in which its count wraps from 0xFFFFFFFF to 0 by counting. Writing 1 to a flag bit clears it, zero bits have no effect, and a flag being set wins over a clear in the same cycle.
- R5: The select register at address 5 holds a 5-bit index and reads back zero-extended. When the index is 4 or more, the event-type and count windows read 0 and writes to them are ignored.
- R6: Address 7 reads and writes the 7-bit event number of the selected event counter. Upper write bits are dropped.
- R7: The cycle count at address 6 is readable and loadable. It advances by one on every clock while global run and its own enable are set. In divide mode it advances only once per 64 such clocks, and the first increment comes on the 64th counting clock after the prescaler is cleared.
- R8: Writing ones to address 3 sets interrupt enables in the counter-mask layout, and the address reads back the enable mask. The interrupt output is high exactly when some counter has both its flag and its interrupt enable set.
- R9: Address 8 reads and loads the count of the selected event counter. That counter advances by one in each cycle in which global run, its enable and its chosen event line are all high. A load in the same cycle takes priority over counting.
- R10: A counter loaded with the two's complement of N and then given N counted events sets its flag on the N-th event and not before.
- R11: While control bit 5 is set and the debug-state input is high, the cycle counter does not advance. The event counters are not affected.
- R12: Trace output bit k is high in a cycle exactly when export is on and event counter k counts in that cycle.
- R13: After reset every register and counter reads 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_lines | input | 2**ETYPE_W (128) | Event input lines, one counting pulse per high cycle |
| dbg_active | input | 1 | Debug-state indication |
| ovf_irq | output | 1 | Shared overflow interrupt |
| evt_trace | output | NUM_EVT (4) | Exported counting pulses of the event counters |

## Verification
The bench builds the block with its default parameters: four event counters, 7-bit event numbers over 128 lines, a 5-bit select index and a prescale of 64. The select index can therefore name counters that do not exist, which exercises the ignored-access path. A divide-by-64 interval fits into a few hundred cycles, so the prescaler tick and its clear are observed directly. Because counts can be loaded near all-ones, wraps, flag-versus-clear collisions and period arming all occur within a short random run, and a behavioural model compares every output on every clock.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int PM_ADDR_W  = 4;
    localparam int PM_BUS_W   = 32;
    localparam int PM_CYC_BIT = 31;

    // register addresses
    typedef enum logic [PM_ADDR_W-1:0] {
        PM_CTRL    = 4'd0,
        PM_EN_SET  = 4'd1,
        PM_EN_CLR  = 4'd2,
        PM_IRQ_SET = 4'd3,
        PM_OVF     = 4'd4,
        PM_SEL     = 4'd5,
        PM_CYC     = 4'd6,
        PM_ETYPE   = 4'd7,
        PM_ECNT    = 4'd8
    } pm_reg_e;

    // control bit positions
    localparam int CB_RUN     = 0;
    localparam int CB_CLR_EVT = 1;
    localparam int CB_CLR_CYC = 2;
    localparam int CB_DIV     = 3;
    localparam int CB_EXPORT  = 4;
    localparam int CB_DBG     = 5;

    typedef struct packed {
        logic dbg_stop;
        logic export_en;
        logic div64;
        logic run;
    } pm_ctrl_t;

endpackage

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (inc) begin
            cnt_d = cnt_q + W'(1);
            wrap  = &cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q;
endmodule

// File: rtl/perfmon_prescale.sv
module perfmon_prescale #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        tick  = adv && (pre_q == PW'(DIV - 1));
        pre_d = pre_q;
        if (clr)       pre_d = '0;
        else if (tick) pre_d = '0;
        else if (adv)  pre_d = pre_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/perfmon_evsel.sv
module perfmon_evsel #(
    parameter int IDX_W = 7
) (
    input  logic [(1<<IDX_W)-1:0] lines,
    input  logic [IDX_W-1:0]      idx,
    output logic                  hit
);
    assign hit = lines[idx];
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
    import perfmon_pkg::*;
#(
    parameter int NUM_EVT  = 4,
    parameter int ETYPE_W  = 7,
    parameter int SEL_W    = 5,
    parameter int PRESCALE = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PM_ADDR_W-1:0]    bus_addr,
    input  logic                    bus_wr,
    input  logic [PM_BUS_W-1:0]     bus_wdata,
    output logic [PM_BUS_W-1:0]     bus_rdata,
    input  logic [(1<<ETYPE_W)-1:0] evt_lines,
    input  logic                    dbg_active,
    output logic                    ovf_irq,
    output logic [NUM_EVT-1:0]      evt_trace
);
    localparam int LINES = 1 << ETYPE_W;
    localparam int NCNT  = NUM_EVT + 1;
    localparam int CYC   = NUM_EVT;
    localparam int CNT_W = PM_BUS_W;

    typedef struct packed {
        pm_ctrl_t                         ctrl;
        logic [NCNT-1:0]                  en;
        logic [NCNT-1:0]                  ien;
        logic [NCNT-1:0]                  ovf;
        logic [SEL_W-1:0]                 sel;
        logic [NUM_EVT-1:0][ETYPE_W-1:0]  etype;
    } state_t;

    state_t st_d, st_q;

    // bus-layout mask <-> internal counter vector
    function automatic logic [NCNT-1:0] to_vec(input logic [PM_BUS_W-1:0] w);
        logic [NCNT-1:0] v;
        v[CYC]           = w[PM_CYC_BIT];
        v[NUM_EVT-1:0]   = w[NUM_EVT-1:0];
        return v;
    endfunction

    function automatic logic [PM_BUS_W-1:0] to_bus(input logic [NCNT-1:0] v);
        logic [PM_BUS_W-1:0] w;
        w                = '0;
        w[PM_CYC_BIT]    = v[CYC];
        w[NUM_EVT-1:0]   = v[NUM_EVT-1:0];
        return w;
    endfunction

    // write decode
    logic wr_ctrl, wr_enset, wr_enclr, wr_ienset, wr_ovf, wr_sel, wr_cyc, wr_ety, wr_ecnt;
    logic clr_evt, clr_cyc;

    assign wr_ctrl   = bus_wr && (bus_addr == PM_CTRL);
    assign wr_enset  = bus_wr && (bus_addr == PM_EN_SET);
    assign wr_enclr  = bus_wr && (bus_addr == PM_EN_CLR);
    assign wr_ienset = bus_wr && (bus_addr == PM_IRQ_SET);
    assign wr_ovf    = bus_wr && (bus_addr == PM_OVF);
    assign wr_sel    = bus_wr && (bus_addr == PM_SEL);
    assign wr_cyc    = bus_wr && (bus_addr == PM_CYC);
    assign wr_ety    = bus_wr && (bus_addr == PM_ETYPE);
    assign wr_ecnt   = bus_wr && (bus_addr == PM_ECNT);
    assign clr_evt   = wr_ctrl && bus_wdata[CB_CLR_EVT];
    assign clr_cyc   = wr_ctrl && bus_wdata[CB_CLR_CYC];

    logic wdata_unused;
    assign wdata_unused = &{1'b0, bus_wdata};

    // event counters
    logic [NUM_EVT-1:0]            evt_hit, evt_inc, evt_wrap, evt_ld;
    logic [NUM_EVT-1:0][CNT_W-1:0] evt_val;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        perfmon_evsel #(.IDX_W(ETYPE_W)) u_sel (
            .lines (evt_lines),
            .idx   (st_q.etype[i]),
            .hit   (evt_hit[i])
        );

        assign evt_inc[i] = st_q.ctrl.run && st_q.en[i] && evt_hit[i];
        assign evt_ld[i]  = wr_ecnt && (st_q.sel == SEL_W'(i));

        perfmon_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr_evt),
            .load     (evt_ld[i]),
            .load_val (bus_wdata),
            .inc      (evt_inc[i]),
            .value    (evt_val[i]),
            .wrap     (evt_wrap[i])
        );
    end

    // cycle counter with optional prescaler
    logic             cyc_adv, cyc_tick, cyc_inc, cyc_wrap;
    logic [CNT_W-1:0] cyc_val;

    assign cyc_adv = st_q.ctrl.run && st_q.en[CYC]
                     && !(st_q.ctrl.dbg_stop && dbg_active);
    assign cyc_inc = cyc_adv && (!st_q.ctrl.div64 || cyc_tick);

    perfmon_prescale #(.DIV(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_cyc),
        .adv   (cyc_adv && st_q.ctrl.div64),
        .tick  (cyc_tick)
    );

    perfmon_counter #(.W(CNT_W)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_cyc),
        .load     (wr_cyc),
        .load_val (bus_wdata),
        .inc      (cyc_inc),
        .value    (cyc_val),
        .wrap     (cyc_wrap)
    );

    logic [NCNT-1:0] wrap_vec;
    assign wrap_vec = {cyc_wrap, evt_wrap};

    // next state
    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl.run       = bus_wdata[CB_RUN];
            st_d.ctrl.div64     = bus_wdata[CB_DIV];
            st_d.ctrl.export_en = bus_wdata[CB_EXPORT];
            st_d.ctrl.dbg_stop  = bus_wdata[CB_DBG];
        end
        if (wr_enset)  st_d.en  = st_q.en | to_vec(bus_wdata);
        if (wr_enclr)  st_d.en  = st_q.en & ~to_vec(bus_wdata);
        if (wr_ienset) st_d.ien = st_q.ien | to_vec(bus_wdata);
        if (wr_sel)    st_d.sel = bus_wdata[SEL_W-1:0];
        for (int i = 0; i < NUM_EVT; i++) begin
            if (wr_ety && (st_q.sel == SEL_W'(i)))
                st_d.etype[i] = bus_wdata[ETYPE_W-1:0];
        end
        st_d.ovf = (st_q.ovf & ~(wr_ovf ? to_vec(bus_wdata) : '0)) | wrap_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            PM_CTRL: begin
                bus_rdata[CB_RUN]    = st_q.ctrl.run;
                bus_rdata[CB_DIV]    = st_q.ctrl.div64;
                bus_rdata[CB_EXPORT] = st_q.ctrl.export_en;
                bus_rdata[CB_DBG]    = st_q.ctrl.dbg_stop;
            end
            PM_EN_SET, PM_EN_CLR: bus_rdata = to_bus(st_q.en);
            PM_IRQ_SET:           bus_rdata = to_bus(st_q.ien);
            PM_OVF:               bus_rdata = to_bus(st_q.ovf);
            PM_SEL:               bus_rdata[SEL_W-1:0] = st_q.sel;
            PM_CYC:               bus_rdata = cyc_val;
            PM_ETYPE: begin
                for (int i = 0; i < NUM_EVT; i++)
                    if (st_q.sel == SEL_W'(i)) bus_rdata[ETYPE_W-1:0] = st_q.etype[i];
            end
            PM_ECNT: begin
                for (int i = 0; i < NUM_EVT; i++)
                    if (st_q.sel == SEL_W'(i)) bus_rdata = evt_val[i];
            end
            default: bus_rdata = '0;
        endcase
    end

    assign ovf_irq   = |(st_q.ovf & st_q.ien);
    assign evt_trace = st_q.ctrl.export_en ? evt_inc : '0;

    // flat views for the bound checker
    logic [NCNT-1:0] ovf_q, en_q, ien_q;
    logic            run_q;
    assign ovf_q = st_q.ovf;
    assign en_q  = st_q.en;
    assign ien_q = st_q.ien;
    assign run_q = st_q.ctrl.run;
endmodule

// File: rtl/perfmon_chk.sv
module perfmon_chk
    import perfmon_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int SEL_W   = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [PM_ADDR_W-1:0] bus_addr,
    input logic [PM_BUS_W-1:0]  bus_wdata,
    input logic [PM_BUS_W-1:0]  bus_rdata,
    input logic                 ovf_irq,
    input logic [NUM_EVT:0]     ovf_q,
    input logic [NUM_EVT:0]     en_q,
    input logic [NUM_EVT:0]     ien_q,
    input logic                 run_q,
    input logic [PM_BUS_W-1:0]  cyc_val
);
    // R1
    ctrl_clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == PM_CTRL) |-> (bus_rdata[2:1] == 2'b00));

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == PM_EN_SET && bus_wdata[0]) |=> en_q[0]);

    // R3
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == PM_EN_CLR && bus_wdata[PM_CYC_BIT]) |=> !en_q[NUM_EVT]);

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == PM_OVF) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

    // R5
    sel_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == PM_SEL) |-> (bus_rdata[PM_BUS_W-1:SEL_W] == '0));

    // R7
    cyc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !(bus_wr && (bus_addr == PM_CTRL || bus_addr == PM_CYC))) |=> $stable(cyc_val));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !ovf_irq);
endmodule

bind perfmon_unit perfmon_chk #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ovf_irq   (ovf_irq),
    .ovf_q     (ovf_q),
    .en_q      (en_q),
    .ien_q     (ien_q),
    .run_q     (run_q),
    .cyc_val   (cyc_val)
);

// File: tb/perfmon_unit_tb.sv
`timescale 1ns/1ps
module perfmon_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   ba = 4'd0;
    logic         bw = 1'b0;
    logic [31:0]  bd = 32'd0;
    logic [31:0]  rdata;
    logic [127:0] evt = '0;
    logic         dbg = 1'b0;
    logic         irq;
    logic [3:0]   trace;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    perfmon_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(ba), .bus_wr(bw), .bus_wdata(bd),
        .bus_rdata(rdata), .evt_lines(evt), .dbg_active(dbg),
        .ovf_irq(irq), .evt_trace(trace)
    );

    // ---------------- behavioural model ----------------
    logic [31:0] m_cnt [4];
    logic [6:0]  m_ety [4];
    logic [31:0] m_ccnt;
    logic [4:0]  m_en, m_ien, m_ovf, m_sel;
    bit          m_run, m_div, m_exp, m_dbs;
    int          m_pre;

    function automatic logic [4:0] b2v(input logic [31:0] w);
        return {w[31], w[3:0]};
    endfunction
    function automatic logic [31:0] v2b(input logic [4:0] v);
        return {v[4], 27'd0, v[3:0]};
    endfunction

    function automatic bit m_counts(input int i);
        return m_run && m_en[i] && evt[m_ety[i]];
    endfunction

    always @(posedge clk) begin : mdl
        bit halted, cadv, cinc, cev, ccy;
        bit [3:0] inc;
        logic [4:0] nov;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_ety[i] = 0; end
            m_ccnt = 0; m_en = 0; m_ien = 0; m_ovf = 0; m_sel = 0;
            m_run = 0; m_div = 0; m_exp = 0; m_dbs = 0; m_pre = 0;
        end else begin
            halted = m_dbs && dbg;
            cadv = m_run && m_en[4] && !halted;
            cinc = cadv && (!m_div || m_pre == 63);
            for (int i = 0; i < 4; i++) inc[i] = m_counts(i);
            cev = bw && ba == 4'd0 && bd[1];
            ccy = bw && ba == 4'd0 && bd[2];
            nov = m_ovf;
            if (bw && ba == 4'd4) nov = nov & ~b2v(bd);
            for (int i = 0; i < 4; i++) begin
                if (cev) m_cnt[i] = 0;
                else if (bw && ba == 4'd8 && m_sel == 5'(i)) m_cnt[i] = bd;
                else if (inc[i]) begin
                    if (m_cnt[i] == 32'hFFFF_FFFF) nov[i] = 1'b1;
                    m_cnt[i] = m_cnt[i] + 1;
                end
            end
            if (ccy) m_ccnt = 0;
            else if (bw && ba == 4'd6) m_ccnt = bd;
            else if (cinc) begin
                if (m_ccnt == 32'hFFFF_FFFF) nov[4] = 1'b1;
                m_ccnt = m_ccnt + 1;
            end
            if (ccy) m_pre = 0;
            else if (cadv && m_div) m_pre = (m_pre + 1) % 64;
            m_ovf = nov;
            if (bw) case (ba)
                4'd0: begin m_run = bd[0]; m_div = bd[3]; m_exp = bd[4]; m_dbs = bd[5]; end
                4'd1: m_en = m_en | b2v(bd);
                4'd2: m_en = m_en & ~b2v(bd);
                4'd3: m_ien = m_ien | b2v(bd);
                4'd5: m_sel = bd[4:0];
                4'd7: if (m_sel < 5'd4) m_ety[m_sel[1:0]] = bd[6:0];
                default: ;
            endcase
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return {26'd0, m_dbs, m_exp, m_div, 2'b00, m_run};
            4'd1, 4'd2: return v2b(m_en);
            4'd3: return v2b(m_ien);
            4'd4: return v2b(m_ovf);
            4'd5: return {27'd0, m_sel};
            4'd6: return m_ccnt;
            4'd7: return (m_sel < 5'd4) ? {25'd0, m_ety[m_sel[1:0]]} : 32'd0;
            4'd8: return (m_sel < 5'd4) ? m_cnt[m_sel[1:0]] : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0: return "R1";
            4'd1, 4'd2: return "R3";
            4'd3: return "R8";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R7 R11";
            4'd7: return "R6";
            4'd8: return "R9";
            default: return "R5 unmapped";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] e;
            logic [3:0]  et;
            e = m_read(ba);
            check(rdata === e, tag_of(ba), rdata, e);
            check(irq === |(m_ovf & m_ien), "R8 irq", {31'd0, irq}, {31'd0, |(m_ovf & m_ien)});
            for (int i = 0; i < 4; i++) et[i] = m_exp && m_counts(i);
            check(trace === et, "R12 trace", {28'd0, trace}, {28'd0, et});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(negedge clk); #1;
    endtask
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        ba = a; bd = d; bw = 1'b1;
        step();
        bw = 1'b0;
    endtask
    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        ba = a; #1;
        check(rdata === exp, tag, rdata, exp);
    endtask
    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        step();

        // R13: reset state
        for (int a = 0; a < 9; a++) rd_chk(4'(a), 32'd0, "R13 reset value");
        check(irq === 1'b0, "R13 irq after reset", {31'd0, irq}, 32'd0);

        // R1: only defined control bits stick
        wr(4'd0, 32'hFFFF_FFFF);
        rd_chk(4'd0, 32'h0000_0039, "R1 control readback");
        wr(4'd0, 32'd0);

        // R3: set / clear enables
        wr(4'd1, 32'hFFFF_FFFF);
        rd_chk(4'd1, 32'h8000_000F, "R3 enable set");
        wr(4'd2, 32'h0000_0006);
        rd_chk(4'd2, 32'h8000_0009, "R3 enable clear");
        wr(4'd2, 32'hFFFF_FFFF);

        // R5 / R6: select and event numbers
        wr(4'd5, 32'hFFFF_FFE2);
        rd_chk(4'd5, 32'h0000_0002, "R5 select width");
        wr(4'd7, 32'h0000_01FF);
        rd_chk(4'd7, 32'h0000_007F, "R6 event number width");
        wr(4'd5, 32'd7);
        wr(4'd7, 32'd9);
        wr(4'd8, 32'h1234_5678);
        rd_chk(4'd8, 32'd0, "R5 out-of-range count");
        rd_chk(4'd7, 32'd0, "R5 out-of-range type");
        wr(4'd5, 32'd2);
        rd_chk(4'd7, 32'h0000_007F, "R5 ignored write kept type");

        // R10: arm counter 0 for a period of 5 on line 5
        wr(4'd5, 32'd0);
        wr(4'd7, 32'd5);
        wr(4'd8, 32'hFFFF_FFFB);
        wr(4'd1, 32'h0000_0001);
        wr(4'd3, 32'h0000_0001);
        wr(4'd0, 32'h0000_0011);
        evt[5] = 1'b1; #1;
        check(trace === 4'b0001, "R12 trace pulse", {28'd0, trace}, 32'd1);
        repeat (4) step();
        evt[5] = 1'b0;
        rd_chk(4'd4, 32'd0, "R10 flag before period");
        check(irq === 1'b0, "R10 irq before period", {31'd0, irq}, 32'd0);
        evt[5] = 1'b1; step(); evt[5] = 1'b0;
        rd_chk(4'd4, 32'h0000_0001, "R10 flag at period");
        check(irq === 1'b1, "R8 irq at overflow", {31'd0, irq}, 32'd1);

        // R4: clear by writing one
        wr(4'd4, 32'h0000_0001);
        rd_chk(4'd4, 32'd0, "R4 flag cleared");

        // R2: event-counter reset
        wr(4'd8, 32'h0000_0100);
        wr(4'd0, 32'h0000_0003);
        rd_chk(4'd8, 32'd0, "R2 event counts cleared");
        rd_chk(4'd0, 32'h0000_0001, "R2 reset bits read zero");

        // R11: debug hold of the cycle counter
        wr(4'd1, 32'h8000_0000);
        wr(4'd0, 32'h0000_0025);
        dbg = 1'b1;
        ba = 4'd6; #1; snap = rdata;
        repeat (10) step();
        rd_chk(4'd6, snap, "R11 cycle held in debug");
        dbg = 1'b0;
        repeat (3) step();
        rd_chk(4'd6, snap + 32'd3, "R11 cycle resumes");

        // R7: divide-by-64 with prescaler clear
        wr(4'd0, 32'h0000_000D);
        repeat (63) step();
        rd_chk(4'd6, 32'd0, "R7 no tick before 64");
        step();
        rd_chk(4'd6, 32'd1, "R7 tick on 64th clock");

        // R4: set wins over clear in the same cycle
        wr(4'd0, 32'h0000_0001);
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd4, 32'h8000_0000);
        rd_chk(4'd4, 32'h8000_0000, "R4 set beats clear");

        // random phase, compared every clock by the model
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] d;
            evt = {$urandom, $urandom, $urandom, $urandom};
            dbg = ($urandom % 4) == 0;
            ba = 4'($urandom % 10);
            case ($urandom % 4)
                0: d = $urandom;
                1: d = 32'hFFFF_FFF0 | ($urandom % 16);
                2: d = ($urandom % 2) ? 32'h8000_000F : 32'h0000_0000;
                default: d = ($urandom % 64);
            endcase
            if (ba == 4'd0) d = d & 32'h3D | 32'h1;
            bd = d;
            bw = ($urandom % 3) == 0;
            step();
        end
        bw = 1'b0;
        step();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule